// File: doc/BRIEF.md
# Card Status Change Interrupt Unit

This unit watches the status pins of up to two removable-card slots and turns their transitions into a single level interrupt request. Each slot has eight input pins: two voltage-sense pins, a write-protect pin, two card-detect pins, two battery-voltage pins and a ready pin. Every pin passes through a synchroniser. A change on a pin is then held in a sticky status bit. Software clears a status bit by writing a one to it.

All slots share one register set. Slot A owns the upper 16-bit half and slot B owns the lower half, and both halves use the same layout. An enable register with the same layout gates the status bits onto the request line. Two ready-level sources are never latched. They read back as the live pin level and drive the request directly while they are enabled. A card counts as present only while both of its detect pins are low. A detect-pin change that leaves the two pins disagreeing raises no event.

A host reads the synchronised pins, the status register or the enable register through a select input. It writes the status or enable register one slot half at a time.

Top module: `csc_irq_unit`

## Requirements
- R1: Bit positions inside each 16-bit slot half are: 15 VS1, 14 VS2, 13 write-protect, 12 CD2, 11 CD1, 10 BVD2, 9 BVD1, 8 RDY, 7 ready-low level, 6 ready-high level, 5 ready rising edge, 4 ready falling edge, and 3..0 reserved. Slot A uses bits 31:16 and slot B uses bits 15:0. The pin input bus uses pin_in[15:8] for slot A and pin_in[7:0] for slot B, with VS1 as the top bit of each byte and RDY as the bottom bit. With rd_sel=0, rd_data returns each slot's synchronised pins in half bits 15:8 and zeros in half bits 7:0. A pin change shows up there two clocks after it is driven.
- R2: A change in either direction on VS1, VS2, write-protect, BVD2, BVD1 or RDY sets that pin's status bit. The bit is set three clocks after the change is driven, and no other latched bit is set.
- R3: A rising RDY sets status bit 5 of its slot and not bit 4. A falling RDY sets bit 4 and not bit 5.
- R4: A change on CD1 or CD2 sets its status bit only if the two synchronised detect pins are equal after the change. If both detect pins change together to equal values, both bits are set.
- R5: A write with wr_sel=0 clears each status bit that has a one in wr_data, within the halves selected by wr_half (wr_half[0] selects slot A, wr_half[1] selects slot B). Zero data bits and unselected halves leave the status unchanged. Rd_sel=1 reads the status register.
- R6: If a status bit is set and cleared in the same clock, the set wins.
- R7: A write with wr_sel=1 loads the enable register, but only in the halves selected by wr_half. Reserved bits 3..0 of each half read back as zero. Rd_sel=2 reads the enable register.
- R8: irq is the OR, over every latched status bit, of the status bit AND its enable bit.
- R9: Status bit 7 reads as NOT RDY and bit 6 reads as RDY, both live. A clear write has no effect on them. While either one is enabled and its level holds, irq is high.
- R10: card_present[0] is high for slot A, and card_present[1] for slot B, exactly when both of that slot's synchronised detect pins are low.
- R11: After reset the status and enable registers hold zero, the synchronised pins read zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 16 | Raw card status pins, slot A in the upper byte |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status (write-one-to-clear), 1 enable |
| wr_half | input | 2 | Half select: bit 0 slot A, bit 1 slot B |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select: 0 pins, 1 status, 2 enable, 3 zero |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt request |
| card_present | output | 2 | Per-slot card presence, bit 0 slot A |

## Verification
A pin edge that is latching into a status bit can reach the register in the same clock as a software clear of that bit. The bench drives a pin transition and then counts two rising edges through the synchroniser. It places the write-one-to-clear strobe so that it is sampled on the same edge that sets the bit. In that same write, the bench also clears an older, already-set bit. The result is judged by reading the status register: the freshly set bit must still be there and the older bit must be gone.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;
   localparam int HALF_W = 16;
   localparam int PIN_W  = 8;

   // pin index inside one slot's pin byte
   localparam int P_VS1  = 7;
   localparam int P_VS2  = 6;
   localparam int P_WP   = 5;
   localparam int P_CD2  = 4;
   localparam int P_CD1  = 3;
   localparam int P_BVD2 = 2;
   localparam int P_BVD1 = 1;
   localparam int P_RDY  = 0;

   // event bit positions inside a slot half
   localparam int B_LVL_LO = 7;
   localparam int B_LVL_HI = 6;
   localparam int B_RISE   = 5;
   localparam int B_FALL   = 4;

   localparam logic [HALF_W-1:0] HALF_LATCH_MASK = 16'hFF30;
   localparam logic [HALF_W-1:0] HALF_LEVEL_MASK = 16'h00C0;
   localparam logic [HALF_W-1:0] HALF_USED_MASK  = 16'hFFF0;

   typedef enum logic [1:0] {
      RD_PINS   = 2'd0,
      RD_STATUS = 2'd1,
      RD_ENABLE = 2'd2,
      RD_ZERO   = 2'd3
   } rd_sel_e;
endpackage

// File: rtl/csc_sync.sv
`timescale 1ns/1ps
module csc_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("csc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/csc_slot.sv
`timescale 1ns/1ps
module csc_slot
   import csc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIN_W-1:0]  pin_s,
   input  logic [HALF_W-1:0] clr,
   output logic [HALF_W-1:0] st_q,
   output logic [HALF_W-1:0] lvl,
   output logic              present
);
   logic [PIN_W-1:0]  prev_q;
   logic [PIN_W-1:0]  chg;
   logic              cd_agree;
   logic [HALF_W-1:0] set_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_s;
   end

   always_comb begin
      chg      = pin_s ^ prev_q;
      cd_agree = (pin_s[P_CD1] == pin_s[P_CD2]);
      set_v    = '0;
      set_v[HALF_W-1 -: PIN_W] = chg;
      // detect events only when both detect pins tell the same story
      if (!cd_agree) begin
         set_v[PIN_W+P_CD1] = 1'b0;
         set_v[PIN_W+P_CD2] = 1'b0;
      end
      set_v[B_RISE] =  pin_s[P_RDY] & ~prev_q[P_RDY];
      set_v[B_FALL] = ~pin_s[P_RDY] &  prev_q[P_RDY];
   end

   // set has priority over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= ((st_q & ~clr) | set_v) & HALF_LATCH_MASK;
   end

   always_comb begin
      lvl           = '0;
      lvl[B_LVL_LO] = ~pin_s[P_RDY];
      lvl[B_LVL_HI] =  pin_s[P_RDY];
   end

   assign present = ~pin_s[P_CD1] & ~pin_s[P_CD2];
endmodule

// File: rtl/csc_irq_unit.sv
`timescale 1ns/1ps
module csc_irq_unit
   import csc_pkg::*;
#(
   parameter int NUM_SLOTS   = 2,
   parameter int SYNC_STAGES = 2,
   localparam int REG_W      = NUM_SLOTS * HALF_W,
   localparam int PIN_BUS_W  = NUM_SLOTS * PIN_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PIN_BUS_W-1:0] pin_in,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic [NUM_SLOTS-1:0] wr_half,
   input  logic [REG_W-1:0]     wr_data,
   input  logic [1:0]           rd_sel,
   output logic [REG_W-1:0]     rd_data,
   output logic                 irq,
   output logic [NUM_SLOTS-1:0] card_present
);
   if (NUM_SLOTS < 1 || NUM_SLOTS > 2) begin : g_bad_slots
      $error("csc_irq_unit: NUM_SLOTS must be 1 or 2");
   end

   logic [PIN_BUS_W-1:0] pin_s;
   logic [REG_W-1:0]     st_all;
   logic [REG_W-1:0]     lvl_all;
   logic [REG_W-1:0]     en_q;
   logic [REG_W-1:0]     pin_view;

   csc_sync #(.W(PIN_BUS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int HB = (NUM_SLOTS - 1 - s) * HALF_W;
      localparam int PB = (NUM_SLOTS - 1 - s) * PIN_W;

      logic [HALF_W-1:0] clr_h;
      logic [HALF_W-1:0] st_h;
      logic [HALF_W-1:0] lvl_h;
      logic [HALF_W-1:0] en_h;

      assign clr_h = (wr_en && !wr_sel && wr_half[s]) ? wr_data[HB +: HALF_W] : '0;

      csc_slot u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_s   (pin_s[PB +: PIN_W]),
         .clr     (clr_h),
         .st_q    (st_h),
         .lvl     (lvl_h),
         .present (card_present[s])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en_h <= '0;
         else if (wr_en && wr_sel && wr_half[s])
            en_h <= wr_data[HB +: HALF_W] & HALF_USED_MASK;
      end

      assign st_all[HB +: HALF_W]   = st_h;
      assign lvl_all[HB +: HALF_W]  = lvl_h;
      assign en_q[HB +: HALF_W]     = en_h;
      assign pin_view[HB +: HALF_W] = {pin_s[PB +: PIN_W], {(HALF_W-PIN_W){1'b0}}};
   end

   assign irq = |((st_all | lvl_all) & en_q);

   always_comb begin
      unique case (rd_sel_e'(rd_sel))
         RD_PINS:   rd_data = pin_view;
         RD_STATUS: rd_data = st_all | lvl_all;
         RD_ENABLE: rd_data = en_q;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/csc_irq_chk.sv
`timescale 1ns/1ps
module csc_irq_chk
   import csc_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   localparam int REG_W    = NUM_SLOTS * HALF_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_sel,
   input logic [1:0]       rd_sel,
   input logic [REG_W-1:0] rd_data,
   input logic [REG_W-1:0] st_all,
   input logic [REG_W-1:0] en_q,
   input logic             irq
);
   logic [REG_W-1:0] latch_mask;
   logic [REG_W-1:0] pin_rsvd;
   always_comb begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
         latch_mask[s*HALF_W +: HALF_W] = HALF_LATCH_MASK;
         pin_rsvd[s*HALF_W +: HALF_W]   = {{PIN_W{1'b0}}, {(HALF_W-PIN_W){1'b1}}};
      end
   end

   // R1
   pin_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == RD_PINS) |-> ((rd_data & pin_rsvd) == '0));

   // R5
   no_silent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !wr_sel) |=> ((st_all & $past(st_all)) == $past(st_all)));

   // R7
   enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel) |=> $stable(en_q));

   // R8
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(st_all & en_q & latch_mask)) |-> irq);

   // R11
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq);
endmodule

bind csc_irq_unit csc_irq_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .rd_sel  (rd_sel),
   .rd_data (rd_data),
   .st_all  (st_all),
   .en_q    (en_q),
   .irq     (irq)
);

// File: tb/csc_irq_unit_bench.sv
`timescale 1ns/1ps
module csc_irq_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pin_in = '0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [1:0]  wr_half = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic        irq;
   logic [1:0]  card_present;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   csc_irq_unit u_csc_irq_unit (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_half(wr_half), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .irq(irq), .card_present(card_present)
   );

   function automatic logic [31:0] lvl_word(input logic [15:0] pv);
      logic [31:0] w;
      w = '0;
      for (int s = 0; s < 2; s++) begin
         w[(1-s)*16+7] = ~pv[(1-s)*8];
         w[(1-s)*16+6] =  pv[(1-s)*8];
      end
      return w;
   endfunction

   function automatic logic [31:0] pin_word(input logic [15:0] pv);
      return {pv[15:8], 8'h00, pv[7:0], 8'h00};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [1:0] half, input logic [31:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_half = half; wr_data = data;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_half = '0; wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] v);
      rd_sel = sel;
      #1;
      v = rd_data;
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      wr(1'b0, 2'b11, 32'hFFFF_FFFF);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] exp;
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // R11 reset state
      rd(2'd1, v); check("R11 status", v, lvl_word(16'h0));
      rd(2'd2, v); check("R11 enable", v, 32'h0);
      rd(2'd0, v); check("R11 pins", v, 32'h0);
      check("R11 irq", {31'b0, irq}, 32'h0);
      check("R10 present both", {30'b0, card_present}, 32'h3);

      // R1 R2 R3 R4 single-pin sweep over both slots
      for (int s = 0; s < 2; s++) begin
         for (int p = 0; p < 8; p++) begin
            clear_all();
            pin_in[(1-s)*8+p] = ~pin_in[(1-s)*8+p];
            tick(4);
            exp = '0;
            if (p != 4 && p != 3) exp[(1-s)*16+8+p] = 1'b1;
            if (p == 0) exp[(1-s)*16 + (pin_in[(1-s)*8] ? 5 : 4)] = 1'b1;
            rd(2'd1, v); check("R2/R3/R4 sweep status", v, exp | lvl_word(pin_in));
            rd(2'd0, v); check("R1 sweep pins", v, pin_word(pin_in));
            pin_in[(1-s)*8+p] = ~pin_in[(1-s)*8+p];
            tick(4);
         end
      end

      // R3 falling ready on slot B
      clear_all();
      pin_in[0] = 1'b1; tick(4); clear_all();
      pin_in[0] = 1'b0; tick(4);
      rd(2'd1, v); check("R3 fall only", v, 32'h0000_0110 | lvl_word(pin_in));
      clear_all();

      // R4 R10 detect agreement on slot A
      pin_in[12] = 1'b1; tick(4);
      rd(2'd1, v); check("R4 disagree suppressed", v, lvl_word(pin_in));
      check("R10 absent on disagree", {30'b0, card_present}, 32'h2);
      pin_in[11] = 1'b1; tick(4);
      rd(2'd1, v); check("R4 agree sets CD1", v, 32'h0800_0000 | lvl_word(pin_in));
      clear_all();
      pin_in[12] = 1'b0; pin_in[11] = 1'b0; tick(4);
      rd(2'd1, v); check("R4 both change", v, 32'h1800_0000 | lvl_word(pin_in));
      check("R10 present again", {30'b0, card_present}, 32'h3);
      clear_all();

      // R5 write-one-to-clear
      pin_in[15] = 1'b1; pin_in[13] = 1'b1; tick(4);
      wr(1'b0, 2'b11, 32'h8000_0000);
      rd(2'd1, v); check("R5 partial clear", v, 32'h2000_0000 | lvl_word(pin_in));
      wr(1'b0, 2'b11, 32'h0);
      rd(2'd1, v); check("R5 zero write", v, 32'h2000_0000 | lvl_word(pin_in));
      wr(1'b0, 2'b10, 32'h2000_0000);
      rd(2'd1, v); check("R5 other half", v, 32'h2000_0000 | lvl_word(pin_in));
      pin_in[15] = 1'b0; pin_in[13] = 1'b0; tick(4);
      clear_all();

      // R6 set and clear in the same cycle
      pin_in[13] = 1'b1; tick(4);
      pin_in[15] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      wr(1'b0, 2'b01, 32'hA000_0000);
      rd(2'd1, v); check("R6 set wins", v, 32'h8000_0000 | lvl_word(pin_in));
      pin_in[15] = 1'b0; pin_in[13] = 1'b0; tick(4);
      clear_all();

      // R7 enable halves
      wr(1'b1, 2'b01, 32'hFFFF_FFFF);
      rd(2'd2, v); check("R7 slot A half", v, 32'hFFF0_0000);
      wr(1'b1, 2'b10, 32'hABCD_1234);
      rd(2'd2, v); check("R7 slot B half", v, 32'hFFF0_1230);
      wr(1'b1, 2'b11, 32'h0);
      rd(2'd2, v); check("R7 both cleared", v, 32'h0);

      // R8 gating
      pin_in[6] = 1'b1; tick(4);
      check("R8 no enable", {31'b0, irq}, 32'h0);
      wr(1'b1, 2'b11, 32'h4000_0000);
      check("R8 wrong slot enabled", {31'b0, irq}, 32'h0);
      wr(1'b1, 2'b11, 32'h0000_4000);
      check("R8 matching enable", {31'b0, irq}, 32'h1);
      wr(1'b0, 2'b11, 32'h0000_4000);
      check("R8 cleared", {31'b0, irq}, 32'h0);
      wr(1'b1, 2'b11, 32'h0);
      pin_in[6] = 1'b0; tick(4);
      clear_all();

      // R9 level sources
      wr(1'b1, 2'b11, 32'h0080_0000);
      check("R9 ready-low irq", {31'b0, irq}, 32'h1);
      wr(1'b0, 2'b11, 32'h0080_0000);
      rd(2'd1, v); check("R9 level not cleared", v, lvl_word(pin_in));
      check("R9 irq holds", {31'b0, irq}, 32'h1);
      pin_in[8] = 1'b1; tick(4);
      check("R9 level gone", {31'b0, irq}, 32'h0);
      rd(2'd1, v); check("R9 status after rise", v, 32'h0120_0000 | lvl_word(pin_in));
      wr(1'b1, 2'b11, 32'h0040_0000);
      check("R9 ready-high irq", {31'b0, irq}, 32'h1);
      wr(1'b1, 2'b11, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule